// File: doc/BRIEF.md
# Packet-Driven Dual-Mode RAM Element

This block is a storage element for a streaming dataflow array. A dual-port RAM sits behind valid/ready packet channels. Nothing moves unless a packet arrives and is accepted. A single configuration input picks how the element behaves.

In RAM mode, an address packet on the read channel produces one 32-bit result packet holding that word. A write needs two packets: an address packet and a data packet. The element stores the word only when both packets are offered together, and it takes both in the same cycle.

In FIFO mode, the data-input channel feeds a first-in first-out buffer, and the result channel drains it. Changing the configuration input empties the FIFO.

Top module: `pktram_elem`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0. In RAM mode with no input valid, `rd_addr_ready` is 1 and both `wr_addr_ready` and `wr_data_ready` are 0.
- R2: In RAM mode, a read address is accepted on a clock edge where `rd_addr_valid` and `rd_addr_ready` are both 1. From the next cycle on, `out_valid` is 1 and `out_data` holds that word. Both stay unchanged until a cycle with `out_ready` = 1 consumes the result.
- R3: In RAM mode, `rd_addr_ready` is 0 while a read result is waiting on the output.
- R4: In RAM mode, `wr_addr_ready` is 1 only when `wr_data_valid` is 1, and `wr_data_ready` is 1 only when `wr_addr_valid` is 1. A lone address packet or a lone data packet is therefore not taken and writes nothing. A pair is taken and written on one edge.
- R5: In RAM mode, a read and a write to the same address accepted on the same edge return the word held before the write.
- R6: With `cfg_fifo` = 1 (FIFO mode), words taken on the data-input channel leave on the result channel in arrival order. A word taken into an empty FIFO is offered two cycles after it is accepted. Both address channels hold their ready at 0.
- R7: In FIFO mode, `out_valid` is 0 while the FIFO is empty. `wr_data_ready` is 0 while it holds DEPTH (default 256) words, so no further word is taken.
- R8: A change of `cfg_fifo` empties the FIFO and resets its pointers. During the cycle in which the change is seen, every ready and `out_valid` are 0. From the next cycle on, the new mode operates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_fifo | input | 1 | Mode select: 0 selects RAM mode, 1 selects FIFO mode |
| rd_addr_valid | input | 1 | Read address packet valid |
| rd_addr_ready | output | 1 | Read address packet accepted |
| rd_addr | input | ADDR_W (8) | Read address |
| wr_addr_valid | input | 1 | Write address packet valid |
| wr_addr_ready | output | 1 | Write address packet accepted |
| wr_addr | input | ADDR_W (8) | Write address |
| wr_data_valid | input | 1 | Data-input packet valid (write data or FIFO input) |
| wr_data_ready | output | 1 | Data-input packet accepted |
| wr_data | input | DATA_W (32) | Data-input word |
| out_valid | output | 1 | Result packet valid |
| out_ready | input | 1 | Result packet consumed |
| out_data | output | DATA_W (32) | Result word |

## Verification
The assertions check, on every cycle, the handshake rules that a single cycle can show:
- A waiting result stays still, and the read channel stays closed while it waits.
- Write address and write data are only ever taken together.
- The address channels stay shut in FIFO mode.
- A mode change leaves the output empty.
- A shadow occupancy count shows that the FIFO never offers a word while empty and never takes one while full.

Data contents need the bench's scenarios:
- the value a read returns;
- the old-data result when a read and a write to one address share an edge;
- FIFO ordering across a full 256-word fill;
- the fact that pointers realign after a mode round trip.

// File: rtl/pktram_pkg.sv
package pktram_pkg;
   typedef enum logic {
      MODE_RAM  = 1'b0,
      MODE_FIFO = 1'b1
   } pe_mode_e;
endpackage

// File: rtl/pktram_dpram.sv
module pktram_dpram #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 256,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   // write port
   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   // registered read port: a same-edge write is not yet visible (old data)
   always_ff @(posedge clk) begin
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/pktram_ram_ctrl.sv
module pktram_ram_ctrl #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 256,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              clr,
   input  logic              rd_valid,
   output logic              rd_ready,
   input  logic [AW-1:0]     rd_addr,
   input  logic              wa_valid,
   output logic              wa_ready,
   input  logic [AW-1:0]     wa_addr,
   input  logic              wd_valid,
   output logic              wd_ready,
   input  logic [DATA_W-1:0] wd_data,
   output logic              res_valid,
   input  logic              res_ready,
   output logic              mem_we,
   output logic [AW-1:0]     mem_waddr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_re,
   output logic [AW-1:0]     mem_raddr
);
   logic pend_q;
   logic rd_fire;

   // a write address and a write data packet are only taken as a pair
   assign wa_ready  = en && wd_valid;
   assign wd_ready  = en && wa_valid;
   assign mem_we    = en && wa_valid && wd_valid;
   assign mem_waddr = wa_addr;
   assign mem_wdata = wd_data;

   // one outstanding read result at most
   assign rd_ready  = en && !pend_q;
   assign rd_fire   = rd_valid && rd_ready;
   assign mem_re    = rd_fire;
   assign mem_raddr = rd_addr;
   assign res_valid = en && pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  pend_q <= 1'b0;
      else if (clr)                pend_q <= 1'b0;
      else if (rd_fire)            pend_q <= 1'b1;
      else if (pend_q && res_ready) pend_q <= 1'b0;
   end
endmodule

// File: rtl/pktram_fifo_ctrl.sv
module pktram_fifo_ctrl #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 256,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              clr,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              res_valid,
   input  logic              res_ready,
   output logic              mem_we,
   output logic [AW-1:0]     mem_waddr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_re,
   output logic [AW-1:0]     mem_raddr
);
   logic [AW-1:0] wp_q, rp_q;
   logic [CW-1:0] cnt_q;      // words still in the RAM
   logic          ov_q;       // word held in the read register
   logic [CW-1:0] occ;
   logic          push;

   assign occ       = cnt_q + CW'(ov_q);
   assign in_ready  = en && (occ < CW'(DEPTH));
   assign push      = in_valid && in_ready;
   assign mem_we    = push;
   assign mem_waddr = wp_q;
   assign mem_wdata = in_data;
   assign mem_re    = en && (cnt_q != '0) && (!ov_q || res_ready);
   assign mem_raddr = rp_q;
   assign res_valid = en && ov_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
         ov_q  <= 1'b0;
      end else if (clr) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
         ov_q  <= 1'b0;
      end else begin
         if (push)   wp_q <= wp_q + AW'(1);
         if (mem_re) rp_q <= rp_q + AW'(1);
         cnt_q <= cnt_q + CW'(push) - CW'(mem_re);
         if (mem_re)         ov_q <= 1'b1;
         else if (res_ready) ov_q <= 1'b0;
      end
   end
endmodule

// File: rtl/pktram_elem.sv
module pktram_elem
   import pktram_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 256,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_fifo,
   input  logic              rd_addr_valid,
   output logic              rd_addr_ready,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              wr_addr_valid,
   output logic              wr_addr_ready,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wr_data_valid,
   output logic              wr_data_ready,
   input  logic [DATA_W-1:0] wr_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("pktram_elem: DATA_W must be at least 1");
      end
      if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
         $error("pktram_elem: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   pe_mode_e mode_q;
   logic     mode_chg, ram_en, fifo_en;

   assign mode_chg = (cfg_fifo != mode_q);
   assign ram_en   = !mode_chg && (mode_q == MODE_RAM);
   assign fifo_en  = !mode_chg && (mode_q == MODE_FIFO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_RAM;
      else        mode_q <= pe_mode_e'(cfg_fifo);
   end

   logic              r_we, r_re, r_wdr, r_vld;
   logic [ADDR_W-1:0] r_waddr, r_raddr;
   logic [DATA_W-1:0] r_wdata;
   logic              f_we, f_re, f_inr, f_vld;
   logic [ADDR_W-1:0] f_waddr, f_raddr;
   logic [DATA_W-1:0] f_wdata;

   pktram_ram_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram_ctrl (
      .clk(clk), .rst_n(rst_n), .en(ram_en), .clr(mode_chg),
      .rd_valid(rd_addr_valid), .rd_ready(rd_addr_ready), .rd_addr(rd_addr),
      .wa_valid(wr_addr_valid), .wa_ready(wr_addr_ready), .wa_addr(wr_addr),
      .wd_valid(wr_data_valid), .wd_ready(r_wdr), .wd_data(wr_data),
      .res_valid(r_vld), .res_ready(out_ready),
      .mem_we(r_we), .mem_waddr(r_waddr), .mem_wdata(r_wdata),
      .mem_re(r_re), .mem_raddr(r_raddr)
   );

   pktram_fifo_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo_ctrl (
      .clk(clk), .rst_n(rst_n), .en(fifo_en), .clr(mode_chg),
      .in_valid(wr_data_valid), .in_ready(f_inr), .in_data(wr_data),
      .res_valid(f_vld), .res_ready(out_ready),
      .mem_we(f_we), .mem_waddr(f_waddr), .mem_wdata(f_wdata),
      .mem_re(f_re), .mem_raddr(f_raddr)
   );

   logic              m_we, m_re;
   logic [ADDR_W-1:0] m_waddr, m_raddr;
   logic [DATA_W-1:0] m_wdata;

   // the controllers are never enabled together
   assign m_we    = r_we | f_we;
   assign m_re    = r_re | f_re;
   assign m_waddr = fifo_en ? f_waddr : r_waddr;
   assign m_wdata = fifo_en ? f_wdata : r_wdata;
   assign m_raddr = fifo_en ? f_raddr : r_raddr;

   assign wr_data_ready = r_wdr | f_inr;
   assign out_valid     = r_vld | f_vld;

   pktram_dpram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
      .clk(clk), .we(m_we), .waddr(m_waddr), .wdata(m_wdata),
      .re(m_re), .raddr(m_raddr), .rdata(out_data)
   );
endmodule

// File: rtl/pktram_elem_chk.sv
module pktram_elem_chk #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 256,
   localparam int CW    = $clog2(DEPTH) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_fifo,
   input logic              mode_chg,
   input logic              rd_addr_valid,
   input logic              rd_addr_ready,
   input logic              wr_addr_valid,
   input logic              wr_addr_ready,
   input logic              wr_data_valid,
   input logic              wr_data_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_data
);
   logic [CW-1:0] occ_q;
   logic          push, pop;

   assign push = wr_data_valid && wr_data_ready;
   assign pop  = out_valid && out_ready;

   // shadow FIFO occupancy
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        occ_q <= '0;
      else if (mode_chg) occ_q <= '0;
      else if (cfg_fifo) occ_q <= occ_q + CW'(push) - CW'(pop);
   end

   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(out_valid && !out_ready) && $stable(cfg_fifo) |-> out_valid && $stable(out_data)); // R2
   AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_fifo && rd_addr_valid && rd_addr_ready) |=> (out_valid || !$stable(cfg_fifo))); // R2
   AST_NO_READ_WHILE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_fifo && out_valid) |-> !rd_addr_ready); // R3
   AST_ADDR_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_fifo && wr_addr_valid && wr_addr_ready) |-> (wr_data_valid && wr_data_ready)); // R4
   AST_DATA_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_fifo && wr_data_valid && wr_data_ready) |-> (wr_addr_valid && wr_addr_ready)); // R4
   AST_FIFO_ADDR_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_fifo |-> (!rd_addr_ready && !wr_addr_ready)); // R6
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_fifo && out_valid) |-> (occ_q != '0)); // R7
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_fifo && wr_data_ready) |-> (occ_q < CW'(DEPTH))); // R7
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      mode_chg |=> !out_valid); // R8
endmodule

bind pktram_elem pktram_elem_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_fifo(cfg_fifo), .mode_chg(mode_chg),
   .rd_addr_valid(rd_addr_valid), .rd_addr_ready(rd_addr_ready),
   .wr_addr_valid(wr_addr_valid), .wr_addr_ready(wr_addr_ready),
   .wr_data_valid(wr_data_valid), .wr_data_ready(wr_data_ready),
   .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/pktram_elem_tb.sv
module pktram_elem_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int DP = 256;

   typedef struct packed {
      logic        is_wr;
      logic [7:0]  addr;
      logic [31:0] data;   // write data, or expected read result
   } vec_t;

   localparam vec_t VEC [8] = '{
      '{1'b1, 8'h10, 32'hDEADBEEF},
      '{1'b1, 8'hFF, 32'h12345678},
      '{1'b1, 8'h00, 32'hA5A5A5A5},
      '{1'b0, 8'h10, 32'hDEADBEEF},
      '{1'b0, 8'hFF, 32'h12345678},
      '{1'b1, 8'h10, 32'h0BADF00D},
      '{1'b0, 8'h10, 32'h0BADF00D},
      '{1'b0, 8'h00, 32'hA5A5A5A5}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_fifo = 1'b0;
   logic rd_addr_valid = 1'b0, wr_addr_valid = 1'b0, wr_data_valid = 1'b0, out_ready = 1'b0;
   logic [7:0] rd_addr = '0, wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic rd_addr_ready, wr_addr_ready, wr_data_ready, out_valid;
   logic [DW-1:0] out_data;
   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pktram_elem #(.DATA_W(DW), .DEPTH(DP)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_fifo(cfg_fifo),
      .rd_addr_valid(rd_addr_valid), .rd_addr_ready(rd_addr_ready), .rd_addr(rd_addr),
      .wr_addr_valid(wr_addr_valid), .wr_addr_ready(wr_addr_ready), .wr_addr(wr_addr),
      .wr_data_valid(wr_data_valid), .wr_data_ready(wr_data_ready), .wr_data(wr_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic ram_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_addr_valid = 1'b1; wr_addr = a; wr_data_valid = 1'b1; wr_data = d;
      #1 chk("R4 pair taken", {30'd0, wr_addr_ready, wr_data_ready}, 32'd3);
      @(posedge clk); #1;
      wr_addr_valid = 1'b0; wr_data_valid = 1'b0;
   endtask

   task automatic ram_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      rd_addr_valid = 1'b1; rd_addr = a;
      #1 chk({tag, " addr ready"}, {31'd0, rd_addr_ready}, 32'd1);
      @(posedge clk); #1 rd_addr_valid = 1'b0;
      @(negedge clk);
      chk({tag, " R2 valid"}, {31'd0, out_valid}, 32'd1);
      chk({tag, " R2 data"}, out_data, exp);
      chk({tag, " R3 busy"}, {31'd0, rd_addr_ready}, 32'd0);
      out_ready = 1'b1;
      @(posedge clk); #1 out_ready = 1'b0;
      @(negedge clk);
      chk({tag, " R2 consumed"}, {31'd0, out_valid}, 32'd0);
   endtask

   task automatic fifo_push(input logic [31:0] d, input string tag);
      @(negedge clk);
      wr_data_valid = 1'b1; wr_data = d;
      #1 chk({tag, " R7 room"}, {31'd0, wr_data_ready}, 32'd1);
      @(posedge clk); #1 wr_data_valid = 1'b0;
   endtask

   task automatic fifo_pop(input logic [31:0] exp, input string tag);
      @(negedge clk);
      chk({tag, " R6 valid"}, {31'd0, out_valid}, 32'd1);
      chk({tag, " R6 order"}, out_data, exp);
      out_ready = 1'b1;
      @(posedge clk); #1 out_ready = 1'b0;
   endtask

   task automatic set_mode(input logic m);
      @(negedge clk);
      cfg_fifo = m;
      #1 chk("R8 switch cycle quiet", {29'd0, rd_addr_ready, wr_data_ready, out_valid}, 32'd0);
      @(posedge clk); @(posedge clk); #1;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      // R1 reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
      chk("R1 rd_addr_ready", {31'd0, rd_addr_ready}, 32'd1);
      chk("R1 write readies", {30'd0, wr_addr_ready, wr_data_ready}, 32'd0);

      // vector table in RAM mode
      for (int i = 0; i < 8; i++) begin
         if (VEC[i].is_wr) ram_write(VEC[i].addr, VEC[i].data);
         else              ram_read(VEC[i].addr, VEC[i].data, "R2 table");
      end

      // R2 result held while output stalled, R3 busy
      @(negedge clk);
      rd_addr_valid = 1'b1; rd_addr = 8'hFF;
      @(posedge clk); #1 rd_addr = 8'h00;
      repeat (3) begin
         @(negedge clk);
         chk("R2 held data", out_data, 32'h12345678);
         chk("R3 no accept while pending", {31'd0, rd_addr_ready}, 32'd0);
      end
      rd_addr_valid = 1'b0; out_ready = 1'b1;
      @(posedge clk); #1 out_ready = 1'b0;

      // R4 lone address, then lone data: no write
      @(negedge clk);
      wr_addr_valid = 1'b1; wr_addr = 8'hFF; wr_data = 32'h55555555;
      #1 chk("R4 lone addr not taken", {31'd0, wr_addr_ready}, 32'd0);
      @(posedge clk); #1 wr_addr_valid = 1'b0; wr_data_valid = 1'b1;
      @(negedge clk);
      chk("R4 lone data not taken", {31'd0, wr_data_ready}, 32'd0);
      @(posedge clk); #1 wr_data_valid = 1'b0;
      ram_read(8'hFF, 32'h12345678, "R4 unchanged");

      // R5 same-edge read and write to one address
      @(negedge clk);
      rd_addr_valid = 1'b1; rd_addr = 8'h33;
      wr_addr_valid = 1'b1; wr_addr = 8'h33; wr_data_valid = 1'b1; wr_data = 32'h11111111;
      @(posedge clk); #1;
      rd_addr_valid = 1'b0; wr_addr_valid = 1'b0; wr_data_valid = 1'b0;
      @(negedge clk); out_ready = 1'b1;
      @(posedge clk); #1 out_ready = 1'b0;
      ram_write(8'h33, 32'h22222222);
      @(negedge clk);
      rd_addr_valid = 1'b1; rd_addr = 8'h33;
      wr_addr_valid = 1'b1; wr_addr = 8'h33; wr_data_valid = 1'b1; wr_data = 32'h33333333;
      @(posedge clk); #1;
      rd_addr_valid = 1'b0; wr_addr_valid = 1'b0; wr_data_valid = 1'b0;
      @(negedge clk);
      chk("R5 old data on collision", out_data, 32'h22222222);
      out_ready = 1'b1;
      @(posedge clk); #1 out_ready = 1'b0;
      ram_read(8'h33, 32'h33333333, "R5 new data after");

      // FIFO mode
      set_mode(1'b1);
      @(negedge clk);
      rd_addr_valid = 1'b1; wr_addr_valid = 1'b1;
      #1 chk("R6 address channels shut", {30'd0, rd_addr_ready, wr_addr_ready}, 32'd0);
      chk("R7 empty no valid", {31'd0, out_valid}, 32'd0);
      rd_addr_valid = 1'b0; wr_addr_valid = 1'b0;

      // R6 two-cycle latency into an empty FIFO
      fifo_push(32'hC0DE0001, "R6 first");
      @(negedge clk);
      chk("R6 not yet valid", {31'd0, out_valid}, 32'd0);
      @(negedge clk);
      chk("R6 valid after two cycles", {31'd0, out_valid}, 32'd1);
      fifo_push(32'hC0DE0002, "R6");
      fifo_push(32'hC0DE0003, "R6");
      fifo_pop(32'hC0DE0001, "R6 p1");
      fifo_pop(32'hC0DE0002, "R6 p2");
      fifo_pop(32'hC0DE0003, "R6 p3");
      @(negedge clk);
      chk("R7 empty after drain", {31'd0, out_valid}, 32'd0);

      // R7 fill to DEPTH, extra word refused, drain in order
      for (int i = 0; i < DP; i++) fifo_push(32'h9000_0000 + i * 3, "R7 fill");
      @(negedge clk);
      wr_data_valid = 1'b1; wr_data = 32'hBAD0BAD0;
      #1 chk("R7 full not ready", {31'd0, wr_data_ready}, 32'd0);
      @(posedge clk); #1 wr_data_valid = 1'b0;
      for (int i = 0; i < DP; i++) fifo_pop(32'h9000_0000 + i * 3, "R7 drain");
      @(negedge clk);
      chk("R7 no extra word", {31'd0, out_valid}, 32'd0);

      // R8 mode round trip empties FIFO and realigns pointers
      fifo_push(32'hAAAA0001, "R8");
      fifo_push(32'hAAAA0002, "R8");
      fifo_push(32'hAAAA0003, "R8");
      set_mode(1'b0);
      set_mode(1'b1);
      @(negedge clk);
      chk("R8 empty after switch", {31'd0, out_valid}, 32'd0);
      fifo_push(32'h77777777, "R8 after");
      @(negedge clk);
      fifo_pop(32'h77777777, "R8 pointer aligned");
      @(negedge clk);
      chk("R8 single word only", {31'd0, out_valid}, 32'd0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule